// File: doc/BRIEF.md
# Serial Clock Prescaler, Two Stages

This block derives the serial clock of a three-wire serial controller from the functional clock. The clock passes through two dividers in a row. The first is a single shared prescaler with four ratios: 2, 4, 7 and 10. The second is a power-of-two divider of 2, 4 or 8, chosen by the mode setting of whichever chip select is active. The serial clock period is the product of the two ratios, counted in functional-clock cycles.

The controller decodes its own registers and hands this block the decoded fields: the prescaler enable, the prescaler ratio code, the active chip select's divider code and the polarity bit. It also supplies a busy level and a one-cycle start pulse. The block drives the serial clock pin. It also produces two one-cycle strobes, aligned to the functional clock, that tell the shift engine when the pin rises and when it falls. A start pulse clears both divider stages, so the first bit always gets a full-length period. The ratio fields are expected to change only together with a start pulse.

Top module: `sck_prescaler`

## Requirements
- R1: While reset is held and after it is released, the pin sits at its idle level (equal to `idle_high`) and both strobes are low.
- R2: The prescaler code `pre_sel` selects the first-stage ratio: 0 selects 2, 1 selects 4, 2 selects 7 and 3 selects 10. The internal stage clock is high for the lower half of each ratio, so ratio 7 is high for 3 cycles and low for 4.
- R3: The divider code `div_sel` selects the second-stage ratio: 0 selects 2, 1 selects 4, 2 selects 8. The unused code 3 also selects 8.
- R4: With P equal to the product of the two ratios, the pin leaves its idle level at the clock edge P/2 cycles after the edge that samples start. It then changes level every P/2 cycles.
- R5: When `idle_high` is 1 the pin idles high and its first transition after start is a falling one. When `idle_high` is 0 the pin idles low and its first transition is a rising one.
- R6: `rise_stb` is high for exactly the one cycle in which the pin first reads high after reading low. `fall_stb` is high for exactly the one cycle in which the pin first reads low after reading high. The two strobes are never high together.
- R7: While `pre_en` is 0 the pin stays at its idle level and no strobe is issued, even if a start pulse arrives.
- R8: When `busy` drops, the pin is back at its idle level one cycle later and no strobe is issued while `busy` stays low.
- R9: A start pulse in the middle of a transfer returns the pin to idle on the next cycle and restarts both stages. The first transition then comes a full P/2 cycles after the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low reset |
| pre_en | input | 1 | Prescaler enable from the clock-control register |
| pre_sel | input | 2 | First-stage ratio code |
| div_sel | input | 2 | Second-stage code of the active chip select |
| idle_high | input | 1 | Polarity bit; 1 makes the pin idle high |
| busy | input | 1 | Controller is running a transfer |
| start | input | 1 | One-cycle start command |
| sclk | output | 1 | Serial clock pin |
| rise_stb | output | 1 | One-cycle strobe on a rising pin edge |
| fall_stb | output | 1 | One-cycle strobe on a falling pin edge |

## Verification
The bench counts clock edges from the edge that samples start, calling it edge 0. After edge k, the expected pin level is the polarity bit XOR ((k / (P/2)) mod 2). A strobe is due in the cycle after edge k whenever k is a nonzero multiple of P/2. Inputs change at falling edges, and every output is compared at the falling edge after each rising edge, so the registered phase and strobes have already settled. The comparison covers every ratio pair and both polarities for two full periods. Turning off the enable, dropping busy or issuing a start all take effect at the next rising edge. The bench therefore checks idle after one cycle, then keeps checking over a long quiet window.

// File: rtl/sck_pkg.sv
package sck_pkg;
  localparam int PRE_RATIO_A = 2;
  localparam int PRE_RATIO_B = 4;
  localparam int PRE_RATIO_C = 7;
  localparam int PRE_RATIO_D = 10;

  function automatic int pre_ratio(input logic [1:0] code);
    case (code)
      2'd0:    return PRE_RATIO_A;
      2'd1:    return PRE_RATIO_B;
      2'd2:    return PRE_RATIO_C;
      default: return PRE_RATIO_D;
    endcase
  endfunction

  // power-of-two second stage; the spare code saturates at the largest ratio
  function automatic int post_ratio(input logic [1:0] code);
    int sh;
    sh = (code == 2'd3) ? 3 : int'(code) + 1;
    return 1 << sh;
  endfunction
endpackage

// File: rtl/sck_stage1.sv
module sck_stage1 #(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick,
  output logic       f_int
);
  import sck_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] half;
  logic             wrap;

  assign ratio = CNT_W'(pre_ratio(sel));
  assign half  = ratio >> 1;
  assign wrap  = (cnt >= ratio - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || restart)  cnt <= '0;
    else if (wrap)             cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  assign tick  = run && !restart && wrap;
  assign f_int = run && !restart && (cnt < half);

  // high-time monitor for the stage clock
  logic [CNT_W-1:0] hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hi_len <= '0;
    else if (!run || restart) hi_len <= '0;
    else if (f_int)           hi_len <= hi_len + 1'b1;
    else                      hi_len <= '0;
  end

  p_stage_duty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && $past(run) && !$past(restart) && $stable(sel) && $fell(f_int))
      |-> (hi_len == half))
    else $error("stage-one high time differs from half the ratio");

  p_tick_in_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !f_int)
    else $error("stage-one tick while stage clock high");
endmodule

// File: rtl/sck_stage2.sv
module sck_stage2 #(
  parameter int CNT_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] code,
  input  logic       tick,
  output logic       phase,
  output logic       lead_q,
  output logic       trail_q
);
  import sck_pkg::*;

  localparam int RW = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [RW-1:0]    ratio;
  logic [RW-1:0]    half;
  logic             lead_evt;
  logic             trail_evt;

  assign ratio     = RW'(post_ratio(code));
  assign half      = ratio >> 1;
  assign lead_evt  = run && !restart && tick && (RW'(cnt) == half - 1'b1);
  assign trail_evt = run && !restart && tick && (RW'(cnt) >= ratio - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; phase <= 1'b0; lead_q <= 1'b0; trail_q <= 1'b0;
    end else if (!run || restart) begin
      cnt <= '0; phase <= 1'b0; lead_q <= 1'b0; trail_q <= 1'b0;
    end else begin
      lead_q  <= lead_evt;
      trail_q <= trail_evt;
      if (tick) begin
        cnt <= trail_evt ? '0 : cnt + 1'b1;
        if (lead_evt)       phase <= 1'b1;
        else if (trail_evt) phase <= 1'b0;
      end
    end
  end

  p_lead_rose_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lead_q |-> $rose(phase))
    else $error("lead strobe without phase rise");

  p_trail_fell_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trail_q |-> $fell(phase))
    else $error("trail strobe without phase fall");

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_q, trail_q}))
    else $error("both phase strobes at once");
endmodule

// File: rtl/sck_edge_out.sv
module sck_edge_out (
  input  logic clk,
  input  logic rst_n,
  input  logic phase,
  input  logic lead_q,
  input  logic trail_q,
  input  logic idle_high,
  output logic sclk,
  output logic rise_stb,
  output logic fall_stb
);
  assign sclk     = phase ^ idle_high;
  assign rise_stb = idle_high ? trail_q : lead_q;
  assign fall_stb = idle_high ? lead_q  : trail_q;

  p_rise_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb && $stable(idle_high)) |-> (sclk && !$past(sclk)))
    else $error("rise strobe without rising pin");

  p_fall_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb && $stable(idle_high)) |-> (!sclk && $past(sclk)))
    else $error("fall strobe without falling pin");
endmodule

// File: rtl/sck_prescaler.sv
module sck_prescaler #(
  parameter int PRE_CNT_W  = 4,
  parameter int POST_CNT_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pre_en,
  input  logic [1:0] pre_sel,
  input  logic [1:0] div_sel,
  input  logic       idle_high,
  input  logic       busy,
  input  logic       start,
  output logic       sclk,
  output logic       rise_stb,
  output logic       fall_stb
);
  logic run;
  logic tick1;
  logic f_int;
  logic phase;
  logic lead_q;
  logic trail_q;

  assign run = pre_en && busy;

  sck_stage1 #(.CNT_W(PRE_CNT_W)) u_stage1 (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(start),
    .sel(pre_sel), .tick(tick1), .f_int(f_int)
  );

  sck_stage2 #(.CNT_W(POST_CNT_W)) u_stage2 (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(start),
    .code(div_sel), .tick(tick1), .phase(phase),
    .lead_q(lead_q), .trail_q(trail_q)
  );

  sck_edge_out u_edge (
    .clk(clk), .rst_n(rst_n), .phase(phase), .lead_q(lead_q),
    .trail_q(trail_q), .idle_high(idle_high),
    .sclk(sclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  p_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pre_en) |-> (sclk == idle_high) && !rise_stb && !fall_stb)
    else $error("activity while prescaler disabled");

  p_busy_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> (sclk == idle_high) && !rise_stb && !fall_stb)
    else $error("activity while controller idle");

  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> (sclk == idle_high) && !rise_stb && !fall_stb)
    else $error("pin not idle after start");
endmodule

// File: tb/sck_prescaler_tb.sv
module sck_prescaler_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pre_en = 1'b0;
  logic [1:0] pre_sel = 2'd0;
  logic [1:0] div_sel = 2'd0;
  logic       idle_high = 1'b1;
  logic       busy = 1'b0;
  logic       start = 1'b0;
  logic       sclk, rise_stb, fall_stb;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sck_prescaler u_dut (
    .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .pre_sel(pre_sel),
    .div_sel(div_sel), .idle_high(idle_high), .busy(busy), .start(start),
    .sclk(sclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int r1_of(input int c);
    int t[4] = '{2, 4, 7, 10};
    return t[c];
  endfunction

  function automatic int r2_of(input int c);
    return (c >= 2) ? 8 : (c == 1 ? 4 : 2);
  endfunction

  task automatic expect_idle(input string req, input int pol, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk({req, " pin"}, int'(sclk), pol);
      chk({req, " strobes"}, int'(rise_stb) + int'(fall_stb), 0);
    end
  endtask

  // start at a falling edge, then follow 2 full periods cycle by cycle
  task automatic follow(input int ps, input int dc, input int pol, input string tag);
    int p, h, ph, pin, edge_due;
    p = r1_of(ps) * r2_of(dc);
    h = p / 2;
    pre_sel = 2'(ps); div_sel = 2'(dc); idle_high = 1'(pol);
    pre_en = 1'b1; busy = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R9 first idle"}, int'(sclk), pol);
    for (int k = 1; k <= 2 * p + 1; k++) begin
      @(negedge clk);
      ph = (k / h) % 2;
      pin = pol ^ ph;
      edge_due = (k % h == 0) ? 1 : 0;
      chk({tag, " R2 R3 R4 R5 pin"}, int'(sclk), pin);
      chk({tag, " R6 rise"}, int'(rise_stb), edge_due & pin);
      chk({tag, " R6 fall"}, int'(fall_stb), edge_due & (1 - pin));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1 pin in reset", int'(sclk), 1);
    chk("R1 strobes in reset", int'(rise_stb) + int'(fall_stb), 0);
    rst_n = 1'b1;
    expect_idle("R1", 1, 4);

    // exhaustive sweep of ratio codes and polarity
    for (int pol = 0; pol < 2; pol++)
      for (int ps = 0; ps < 4; ps++)
        for (int dc = 0; dc < 4; dc++)
          follow(ps, dc, pol, "sweep");

    // R7: disabled prescaler ignores busy and start
    pre_en = 1'b0; busy = 1'b1; pre_sel = 2'd0; div_sel = 2'd0; idle_high = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    expect_idle("R7", 0, 60);

    // R8: drop busy while the pin is away from idle
    pre_en = 1'b1; busy = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 pin active before drop", int'(sclk), 1);
    busy = 1'b0;
    expect_idle("R8", 0, 40);

    // R9: restart mid-transfer with the pin away from idle
    pre_sel = 2'd3; div_sel = 2'd2; idle_high = 1'b1;
    busy = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    chk("R9 pin active before restart", int'(sclk), 0);
    follow(3, 2, 1, "restart");
    follow(2, 0, 0, "restart");

    busy = 1'b0;
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule